// File: doc/BRIEF.md
# Multi-Level Trigger Sequencer

This block watches a bus of probed signals and produces one trigger pulse once a chain of programmed trigger levels has been satisfied in order. Each level holds a 3-bit condition for every probed bit. A level matches on a sample when every bit meets its condition. Edge conditions compare the sample taken at the current rising clock edge with the sample taken at the edge before it. The levels are walked one at a time, and the trigger fires on the sample that satisfies the last configured level.

An external trigger input, with its own selectable level or edge condition, can fire the trigger at any point while the sequencer is armed. The trigger output is a one-cycle pulse meant to drive the trigger input of another capture instance or an external instrument. A sticky flag stays set after firing until the next arm. Conditions, the number of active levels and the external trigger mode are all written through a small register write port.

Top module: `trig_seq_unit`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `trig_o` and `triggered_o` are 0 and `level_o` is 0. Reset sets every condition to 0, the level count to 1 and the external mode to 0.
- R2: The condition codes per bit are 0 = don't care, 1 = low, 2 = high, 3 = rising (previous 0, current 1), 4 = falling (previous 1, current 0) and 5 = either edge (previous differs from current). Codes 6 and 7 act as don't care. A level matches when all of its bits meet their conditions.
- R3: The previous sample used by the edge codes is registered on every clock edge, whether or not the block is armed, and resets to 0.
- R4: Only the level indexed by `level_o` is evaluated. A match raises `level_o` by one at the next edge. Later levels that happen to match on the same sample are not counted.
- R5: The level count comes from a write with select 1. Written values are clamped to the range 1..MAX_LEVELS, so 0 acts as 1. The trigger fires on the match that brings `level_o` to at least the level count, so after a full chain `level_o` equals the count.
- R6: `trig_o` is high for exactly one cycle: the cycle after the clock edge that sampled the firing condition. `triggered_o` rises in that same cycle.
- R7: After firing, neither level progress nor a new pulse occurs until `arm_i` is asserted. `triggered_o` stays 1 until then. `arm_i` takes priority over matching: at the next edge it clears `triggered_o` and `level_o`, and it evaluates no condition on that sample.
- R8: The external mode is written with select 2 and uses the codes 1..5 of R2, applied to `ext_trig_i` against its own previous sample. Modes 0, 6 and 7 disable the external trigger. While armed and not yet fired, an external match fires the trigger and leaves `level_o` unchanged unless the current level also matched.
- R9: After reset and before the first arm, no input pattern advances `level_o` or raises `trig_o`.
- R10: A write with select 0 stores `cfg_data_i[2:0]` as the code of bit `cfg_bit_i` of level `cfg_lvl_i`. Select 3 writes nothing. A write takes effect for samples from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Acquisition clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| probe_i | input | PROBE_W | Probed signals |
| ext_trig_i | input | 1 | External trigger input |
| arm_i | input | 1 | Restart the level sequence and clear the sticky flag |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | 0 condition cell, 1 level count, 2 external mode, 3 none |
| cfg_lvl_i | input | LVL_W | Level index for a cell write |
| cfg_bit_i | input | BIT_W | Bit index for a cell write |
| cfg_data_i | input | CFG_DW | Write data |
| trig_o | output | 1 | One-cycle trigger pulse |
| triggered_o | output | 1 | Sticky fired flag |
| level_o | output | LVL_W | Number of levels satisfied since the last arm |

## Verification
The bench builds the block with a 4-bit probe bus and the full ten levels. With only four bits, random patterns satisfy random conditions often, so long chains run to completion and the external edge path fires regularly. Ten levels bring the clamp at the maximum count and a full-depth walk of `level_o` within reach. A random phase also rewrites the level count and cells while a chain is in progress, so it covers lowering the count below the current level.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int COND_W = 3;

  localparam logic [COND_W-1:0] COND_ANY  = 3'd0;
  localparam logic [COND_W-1:0] COND_LOW  = 3'd1;
  localparam logic [COND_W-1:0] COND_HIGH = 3'd2;
  localparam logic [COND_W-1:0] COND_RISE = 3'd3;
  localparam logic [COND_W-1:0] COND_FALL = 3'd4;
  localparam logic [COND_W-1:0] COND_EDGE = 3'd5;

  typedef enum logic [1:0] {
    SEL_CELL  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_EXT   = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  function automatic logic cond_met(input logic [COND_W-1:0] code,
                                    input logic cur, input logic prev);
    case (code)
      COND_LOW:  return !cur;
      COND_HIGH: return cur;
      COND_RISE: return cur && !prev;
      COND_FALL: return !cur && prev;
      COND_EDGE: return cur ^ prev;
      default:   return 1'b1;
    endcase
  endfunction

  function automatic logic ext_mode_active(input logic [COND_W-1:0] code);
    return (code != COND_ANY) && (code <= COND_EDGE);
  endfunction
endpackage

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_pkg::*;
#(
  parameter int PROBE_W    = 8,
  parameter int MAX_LEVELS = 10,
  parameter int LVL_W      = 4,
  parameter int BIT_W      = 3,
  parameter int CFG_DW     = 4
) (
  input  logic                                         clk_i,
  input  logic                                         rst_ni,
  input  logic                                         we_i,
  input  logic [1:0]                                   sel_i,
  input  logic [LVL_W-1:0]                             lvl_i,
  input  logic [BIT_W-1:0]                             bit_i,
  input  logic [CFG_DW-1:0]                            data_i,
  output logic [MAX_LEVELS-1:0][PROBE_W-1:0][COND_W-1:0] codes_o,
  output logic [LVL_W-1:0]                             nlev_o,
  output logic [COND_W-1:0]                            ext_mode_o
);
  logic [LVL_W-1:0]  nlev_q, nlev_clamped;
  logic [COND_W-1:0] ext_mode_q;

  always_comb begin
    if (data_i == '0)                    nlev_clamped = LVL_W'(1);
    else if (int'(data_i) > MAX_LEVELS)  nlev_clamped = LVL_W'(MAX_LEVELS);
    else                                 nlev_clamped = LVL_W'(data_i);
  end

  for (genvar l = 0; l < MAX_LEVELS; l++) begin : g_lvl
    logic hit_lvl;
    assign hit_lvl = we_i && (cfg_sel_e'(sel_i) == SEL_CELL) && (lvl_i == LVL_W'(l));
    for (genvar b = 0; b < PROBE_W; b++) begin : g_bit
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                             codes_o[l][b] <= COND_ANY;
        else if (hit_lvl && bit_i == BIT_W'(b))  codes_o[l][b] <= data_i[COND_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nlev_q     <= LVL_W'(1);
      ext_mode_q <= COND_ANY;
    end else if (we_i) begin
      if (cfg_sel_e'(sel_i) == SEL_COUNT) nlev_q     <= nlev_clamped;
      if (cfg_sel_e'(sel_i) == SEL_EXT)   ext_mode_q <= data_i[COND_W-1:0];
    end
  end

  assign nlev_o     = nlev_q;
  assign ext_mode_o = ext_mode_q;
endmodule

// File: rtl/trig_level_eval.sv
module trig_level_eval
  import trig_pkg::*;
#(
  parameter int PROBE_W    = 8,
  parameter int MAX_LEVELS = 10
) (
  input  logic [MAX_LEVELS-1:0][PROBE_W-1:0][COND_W-1:0] codes_i,
  input  logic [PROBE_W-1:0]                             cur_i,
  input  logic [PROBE_W-1:0]                             prev_i,
  output logic [MAX_LEVELS-1:0]                          hit_o
);
  for (genvar l = 0; l < MAX_LEVELS; l++) begin : g_lvl
    logic [PROBE_W-1:0] bit_ok;
    for (genvar b = 0; b < PROBE_W; b++) begin : g_bit
      assign bit_ok[b] = cond_met(codes_i[l][b], cur_i[b], prev_i[b]);
    end
    assign hit_o[l] = &bit_ok;
  end
endmodule

// File: rtl/trig_seq_ctrl.sv
module trig_seq_ctrl #(
  parameter int MAX_LEVELS = 10,
  parameter int LVL_W      = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  arm_i,
  input  logic [MAX_LEVELS-1:0] hit_i,
  input  logic                  ext_hit_i,
  input  logic [LVL_W-1:0]      nlev_i,
  output logic [LVL_W-1:0]      level_o,
  output logic                  trig_o,
  output logic                  done_o,
  output logic                  armed_o
);
  localparam int SPAN = 1 << LVL_W;

  logic [LVL_W-1:0] lvl_q;
  logic             trig_q, done_q, armed_q;
  logic [SPAN-1:0]  hit_pad;
  logic             cur_hit, last_lvl, active;

  assign hit_pad  = SPAN'(hit_i);
  assign cur_hit  = hit_pad[lvl_q];
  assign last_lvl = ({1'b0, lvl_q} + (LVL_W+1)'(1)) >= {1'b0, nlev_i};
  assign active   = armed_q && !done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= '0;
      trig_q  <= 1'b0;
      done_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      trig_q <= 1'b0;
      if (arm_i) begin
        lvl_q   <= '0;
        done_q  <= 1'b0;
        armed_q <= 1'b1;
      end else if (active) begin
        if (cur_hit) lvl_q <= lvl_q + LVL_W'(1);
        if ((cur_hit && last_lvl) || ext_hit_i) begin
          trig_q <= 1'b1;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign level_o = lvl_q;
  assign trig_o  = trig_q;
  assign done_o  = done_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/trig_seq_unit.sv
module trig_seq_unit
  import trig_pkg::*;
#(
  parameter  int PROBE_W    = 8,
  parameter  int MAX_LEVELS = 10,
  localparam int LVL_W      = $clog2(MAX_LEVELS + 1),
  localparam int BIT_W      = (PROBE_W > 1) ? $clog2(PROBE_W) : 1,
  localparam int CFG_DW     = (LVL_W > COND_W) ? LVL_W : COND_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PROBE_W-1:0] probe_i,
  input  logic               ext_trig_i,
  input  logic               arm_i,
  input  logic               cfg_we_i,
  input  logic [1:0]         cfg_sel_i,
  input  logic [LVL_W-1:0]   cfg_lvl_i,
  input  logic [BIT_W-1:0]   cfg_bit_i,
  input  logic [CFG_DW-1:0]  cfg_data_i,
  output logic               trig_o,
  output logic               triggered_o,
  output logic [LVL_W-1:0]   level_o
);
  logic [MAX_LEVELS-1:0][PROBE_W-1:0][COND_W-1:0] codes;
  logic [LVL_W-1:0]      nlev;
  logic [COND_W-1:0]     ext_mode;
  logic [PROBE_W-1:0]    prev_q;
  logic                  ext_prev_q;
  logic [MAX_LEVELS-1:0] hit;
  logic                  ext_hit;
  logic                  armed;

  trig_cfg_regs #(
    .PROBE_W(PROBE_W), .MAX_LEVELS(MAX_LEVELS),
    .LVL_W(LVL_W), .BIT_W(BIT_W), .CFG_DW(CFG_DW)
  ) i_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .lvl_i(cfg_lvl_i),
    .bit_i(cfg_bit_i), .data_i(cfg_data_i),
    .codes_o(codes), .nlev_o(nlev), .ext_mode_o(ext_mode)
  );

  // previous sample for edge codes, taken every edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q     <= '0;
      ext_prev_q <= 1'b0;
    end else begin
      prev_q     <= probe_i;
      ext_prev_q <= ext_trig_i;
    end
  end

  trig_level_eval #(.PROBE_W(PROBE_W), .MAX_LEVELS(MAX_LEVELS)) i_eval (
    .codes_i(codes), .cur_i(probe_i), .prev_i(prev_q), .hit_o(hit)
  );

  assign ext_hit = ext_mode_active(ext_mode) && cond_met(ext_mode, ext_trig_i, ext_prev_q);

  trig_seq_ctrl #(.MAX_LEVELS(MAX_LEVELS), .LVL_W(LVL_W)) i_ctrl (
    .clk_i, .rst_ni, .arm_i,
    .hit_i(hit), .ext_hit_i(ext_hit), .nlev_i(nlev),
    .level_o, .trig_o, .done_o(triggered_o), .armed_o(armed)
  );
endmodule

// File: rtl/trig_seq_unit_chk.sv
module trig_seq_unit_chk #(
  parameter int LVL_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             arm_i,
  input logic             armed,
  input logic             trig_o,
  input logic             triggered_o,
  input logic [LVL_W-1:0] level_o
);
  p_pulse_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);

  p_pulse_sets_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> triggered_o);

  p_flag_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (triggered_o && !arm_i) |=> (triggered_o && $stable(level_o) && !trig_o));

  p_arm_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (!triggered_o && !trig_o && level_o == '0));

  p_level_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (level_o == $past(level_o) || level_o == $past(level_o) + LVL_W'(1)));

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed && !arm_i) |=> (!trig_o && $stable(level_o)));
endmodule

bind trig_seq_unit trig_seq_unit_chk #(.LVL_W(LVL_W)) i_chk (
  .clk_i, .rst_ni, .arm_i, .armed, .trig_o, .triggered_o, .level_o
);

// File: tb/test_trig_seq_unit.sv
module test_trig_seq_unit;
  localparam int PW     = 4;
  localparam int ML     = 10;
  localparam int LW     = $clog2(ML + 1);
  localparam int BW     = $clog2(PW);
  localparam int DW     = (LW > 3) ? LW : 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PW-1:0] probe = '0;
  logic          ext = 1'b0, arm = 1'b0, cfg_we = 1'b0;
  logic [1:0]    cfg_sel = 2'd3;
  logic [LW-1:0] cfg_lvl = '0;
  logic [BW-1:0] cfg_bit = '0;
  logic [DW-1:0] cfg_data = '0;
  logic          trig, trigd;
  logic [LW-1:0] level;

  int checks = 0, failures = 0;

  // reference model state
  int m_code[ML][PW];
  int m_nlev = 1, m_ext = 0, m_lvl = 0;
  int m_prev[PW];
  int m_eprev = 0;
  bit m_trig = 0, m_done = 0, m_armed = 0;

  always #4 clk = ~clk;

  trig_seq_unit #(.PROBE_W(PW), .MAX_LEVELS(ML)) i_trig_seq_unit (
    .clk_i(clk), .rst_ni(rst_n), .probe_i(probe), .ext_trig_i(ext), .arm_i(arm),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_lvl_i(cfg_lvl), .cfg_bit_i(cfg_bit),
    .cfg_data_i(cfg_data), .trig_o(trig), .triggered_o(trigd), .level_o(level)
  );

  function automatic bit f_cond(int code, int cur, int prev);
    case (code)
      1: return cur == 0;
      2: return cur == 1;
      3: return cur == 1 && prev == 0;
      4: return cur == 0 && prev == 1;
      5: return cur != prev;
      default: return 1;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit hit, ehit, last;
    hit = 0;
    if (m_lvl < ML) begin
      hit = 1;
      for (int b = 0; b < PW; b++)
        if (!f_cond(m_code[m_lvl][b], int'(probe[b]), m_prev[b])) hit = 0;
    end
    ehit = (m_ext >= 1 && m_ext <= 5) && f_cond(m_ext, int'(ext), m_eprev);
    last = (m_lvl + 1) >= m_nlev;
    m_trig = 0;
    if (arm) begin
      m_lvl = 0; m_done = 0; m_armed = 1;
    end else if (m_armed && !m_done) begin
      if ((hit && last) || ehit) begin m_trig = 1; m_done = 1; end
      if (hit) m_lvl++;
    end
    if (cfg_we) begin
      case (cfg_sel)
        2'd0: if (int'(cfg_lvl) < ML) m_code[cfg_lvl][cfg_bit] = int'(cfg_data[2:0]);
        2'd1: m_nlev = (cfg_data == 0) ? 1 : (int'(cfg_data) > ML ? ML : int'(cfg_data));
        2'd2: m_ext = int'(cfg_data[2:0]);
        default: ;
      endcase
    end
    for (int b = 0; b < PW; b++) m_prev[b] = int'(probe[b]);
    m_eprev = int'(ext);
  endtask

  task automatic cycle(input logic a, input logic [PW-1:0] p, input logic e);
    arm = a; probe = p; ext = e;
    @(posedge clk);
    model_step();
    #2;
    chk("R4 level_o", int'(level), m_lvl);
    chk("R6 trig_o", int'(trig), int'(m_trig));
    chk("R7 triggered_o", int'(trigd), int'(m_done));
    cfg_we = 0; arm = 0;
  endtask

  task automatic wr(input int sel, input int lv, input int bt, input int d);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_lvl = LW'(lv); cfg_bit = BW'(bt); cfg_data = DW'(d);
    cycle(1'b0, probe, ext);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog expired (all requirements)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int l = 0; l < ML; l++) for (int b = 0; b < PW; b++) m_code[l][b] = 0;
    for (int b = 0; b < PW; b++) m_prev[b] = 0;
    void'($urandom(32'h5eed_0042));

    // R1: reset state
    #3;
    chk("R1 trig_o in reset", int'(trig), 0);
    chk("R1 triggered_o in reset", int'(trigd), 0);
    chk("R1 level_o in reset", int'(level), 0);
    #20 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 level_o after reset", int'(level), 0);

    // R9: not armed, everything don't care, no progress
    for (int i = 0; i < 6; i++) begin
      cycle(1'b0, PW'(i), i[0]);
      chk("R9 no trig before arm", int'(trig), 0);
      chk("R9 level held before arm", int'(level), 0);
    end

    // R5: count clamps to maximum, full-depth walk
    wr(1, 0, 0, 15);
    cycle(1'b1, '0, 1'b0);
    for (int k = 1; k < ML; k++) begin
      cycle(1'b0, '0, 1'b0);
      chk("R5 level walk", int'(level), k);
      chk("R5 no early trig", int'(trig), 0);
    end
    cycle(1'b0, '0, 1'b0);
    chk("R5 fire at clamped max", int'(trig), 1);
    chk("R5 level equals count", int'(level), ML);
    // R5: count 0 acts as 1
    wr(1, 0, 0, 0);
    cycle(1'b1, '0, 1'b0);
    cycle(1'b0, '0, 1'b0);
    chk("R5 zero count fires after one level", int'(trig), 1);
    chk("R5 zero count level", int'(level), 1);

    // R4: ordered levels, L0 needs bit0 high, L1 needs bit1 high (R10 writes)
    wr(1, 0, 0, 2);
    wr(0, 0, 0, 2);
    wr(0, 1, 1, 2);
    cycle(1'b1, '0, 1'b0);
    cycle(1'b0, 4'b0010, 1'b0);
    chk("R4 later level ignored before earlier", int'(level), 0);
    cycle(1'b0, 4'b0011, 1'b0);
    chk("R4 one level per sample", int'(level), 1);
    chk("R4 no trig yet", int'(trig), 0);
    cycle(1'b0, 4'b0001, 1'b0);
    chk("R4 level held on miss", int'(level), 1);
    cycle(1'b0, 4'b0010, 1'b0);
    chk("R6 trig after last level", int'(trig), 1);
    chk("R6 flag with pulse", int'(trigd), 1);
    // R7: sticky and no re-fire
    cycle(1'b0, 4'b0011, 1'b0);
    chk("R6 pulse one cycle", int'(trig), 0);
    chk("R7 flag sticky", int'(trigd), 1);
    chk("R7 level frozen", int'(level), 2);
    cycle(1'b1, 4'b0011, 1'b0);
    chk("R7 arm clears flag", int'(trigd), 0);
    chk("R7 arm clears level", int'(level), 0);
    chk("R7 arm sample not evaluated", int'(trig), 0);

    // R8: external trigger modes, level 0 kept unmatched
    wr(1, 0, 0, 1);
    wr(2, 0, 0, 3);
    cycle(1'b1, '0, 1'b0);
    cycle(1'b0, '0, 1'b1);
    chk("R8 external rising fires", int'(trig), 1);
    chk("R8 level unchanged", int'(level), 0);
    wr(2, 0, 0, 0);
    cycle(1'b1, '0, 1'b0);
    cycle(1'b0, '0, 1'b1);
    cycle(1'b0, '0, 1'b0);
    chk("R8 mode 0 disabled", int'(trigd), 0);
    wr(2, 0, 0, 6);
    cycle(1'b0, '0, 1'b1);
    chk("R8 mode 6 disabled", int'(trigd), 0);
    wr(2, 0, 0, 4);
    cycle(1'b1, '0, 1'b1);
    cycle(1'b0, '0, 1'b0);
    chk("R8 external falling fires", int'(trig), 1);
    wr(2, 0, 0, 0);

    // R2,R3: every code on bit0, previous sample set during the arm cycle
    begin
      int tc[14][4] = '{'{0,0,0,1},'{1,1,0,1},'{1,0,1,0},'{2,0,1,1},'{2,1,0,0},
                        '{3,0,1,1},'{3,1,1,0},'{4,1,0,1},'{4,0,0,0},'{5,1,0,1},
                        '{5,0,1,1},'{5,1,1,0},'{6,0,1,1},'{7,1,0,1}};
      for (int i = 0; i < 14; i++) begin
        wr(0, 0, 0, tc[i][0]);
        cycle(1'b1, PW'(tc[i][1]), 1'b0);
        cycle(1'b0, PW'(tc[i][2]), 1'b0);
        chk($sformatf("R2 code %0d prev %0d cur %0d (R3)", tc[i][0], tc[i][1], tc[i][2]),
            int'(trig), tc[i][3]);
      end
    end

    // R10 cell writes: select 3 writes nothing
    wr(0, 0, 0, 2);
    wr(3, 0, 0, 1);
    cycle(1'b1, '0, 1'b0);
    cycle(1'b0, 4'b0001, 1'b0);
    chk("R10 select 3 ignored", int'(trig), 1);

    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(99) < 6) begin
        int s, d;
        s = $urandom_range(2);
        d = (s == 1) ? $urandom_range(15) : (($urandom_range(2) == 0) ? $urandom_range(7) : 0);
        cfg_we = 1; cfg_sel = 2'(s); cfg_lvl = LW'($urandom_range(ML-1));
        cfg_bit = BW'($urandom_range(PW-1)); cfg_data = DW'(d);
      end
      cycle(($urandom_range(99) < 4), PW'($urandom), ($urandom_range(9) < 3) ? ~ext : ext);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule